// File: doc/BRIEF.md
# Zoned Associative Address Translation Lookup

This block translates a 32-bit virtual address into a physical address by searching a table of translation entries in parallel. Each entry pairs a tag word, which holds a virtual page number, a page-size code and a valid flag, with a data word. The data word holds a real page number, write and execute permission flags and a zone selector. Each entry also keeps an 8-bit owner ID. Pages may be anywhere from 1 KiB to 16 MiB in size. The number of offset bits taken from the virtual address therefore differs from entry to entry.

A 32-bit zone register holds sixteen 2-bit protection codes. The selector of an entry picks one of these codes. The code can hide the entry from user-mode accesses, use the entry's own permission flags, or grant write and execute rights regardless of those flags. An access is a read, a write or a fetch. The outcome is reported one clock after the request as exactly one of: hit, protection fault or miss. A hit also reports the entry index, the physical address, the page-size code and the granted rights.

Entries are loaded through an indexed write port that takes one word per cycle. When a tag word is written, the entry's owner ID is taken from the current process ID at that moment.

Top module: `tlb_zone_lookup`

## Requirements
- R1: Synchronous reset invalidates every entry and drives all result outputs to zero. After reset, any lookup is a miss.
- R2: The tag word fields are: page number in bits [31:10], size code in bits [9:7], valid flag in bit 6. Size codes 0 to 7 give page sizes of 1 KiB, 4 KiB, 16 KiB, 64 KiB, 256 KiB, 1 MiB, 4 MiB and 16 MiB. An entry's address matches when the virtual address and the stored page number agree on every bit above the page offset.
- R3: An owner ID of zero matches every process. A nonzero owner ID matches only when it equals bits [7:0] of the process ID.
- R4: When several entries are eligible, the one with the lowest index decides the outcome.
- R5: The data word fields are: real page number in bits [31:10], execute flag in bit 9, write flag in bit 8, zone selector in bits [7:4]. The selector z reads its code from zone-register bits [31-2z:30-2z]. Code 0 makes the entry invisible to user-mode accesses, so the search moves on to higher indices. Supervisor accesses still see the entry and use its own flags.
- R6: Code 1 uses the entry's flags. Code 2 grants write and execute to supervisor accesses only. Code 3 grants both to every access.
- R7: The access type is encoded as 0 for read, 1 for write and 2 for fetch. If the deciding entry lacks write rights for a write, or execute rights for a fetch, the result is a protection fault. A fault reports index, address and size as zero, and no higher entry is considered.
- R8: On a hit, the outputs are: the entry index; the physical address, which is (real page AND mask) OR (virtual address AND NOT mask) where mask clears the offset bits; the size code; and the rights {read=1, write, execute}. A fault reports the same rights, with read set.
- R9: The result registers one clock after the lookup inputs. Exactly one of hit, miss or fault is set for each lookup. A miss reports no rights.
- R10: A tag-word write (write select 0) stores the current process ID bits [7:0] as the entry's owner ID. A data-word write (select 1) leaves the owner ID unchanged.

Top module ports are listed below in declaration order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write one word of an entry |
| wr_word | input | 1 | 0 = tag word, 1 = data word |
| wr_idx | input | 6 | Entry index to write |
| wr_data | input | 32 | Word to write |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_acc | input | 2 | Access type: 0 read, 1 write, 2 fetch |
| lk_user | input | 1 | 1 = user mode, 0 = supervisor |
| cur_pid | input | 32 | Current process ID; bits [7:0] are used |
| zone_reg | input | 32 | Sixteen 2-bit zone protection codes |
| res_hit | output | 1 | Translation succeeded |
| res_miss | output | 1 | No eligible entry |
| res_fault | output | 1 | Deciding entry denies the access |
| res_idx | output | 6 | Index of the hitting entry |
| res_paddr | output | 32 | Translated physical address |
| res_size | output | 3 | Size code of the hitting entry |
| res_r | output | 1 | Read right granted |
| res_w | output | 1 | Write right granted |
| res_x | output | 1 | Execute right granted |

## Verification
The hardest case to create is a user-mode search that skips a lower entry hidden by zone code 0 and then resolves on a higher entry. The same address must give the lower index in supervisor mode. The bench creates this by loading two entries for the same page with different zone selectors, then issuing the same address in both modes. A second hard case is a fault on a low entry that must stop the search even though a higher entry would grant the access. The bench loads a permission-less entry below a fully permitted one for the same page and issues a write and a fetch.

// File: rtl/tlb_zone_pkg.sv
package tlb_zone_pkg;
  localparam int WORD_W = 32;
  localparam int OWNER_W = 8;
  localparam int OFS_MIN = 10;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  // Mask that keeps the page-number bits for a size code (1 KiB << 2*code).
  function automatic logic [WORD_W-1:0] page_mask(input logic [2:0] code);
    return ~((WORD_W'(1024) << {code, 1'b0}) - WORD_W'(1));
  endfunction
endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
  import tlb_zone_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              wr_en,
  input  logic                              wr_word,
  input  logic [IDX_W-1:0]                  wr_idx,
  input  logic [WORD_W-1:0]                 wr_data,
  input  logic [OWNER_W-1:0]                wr_owner,
  output logic [ENTRIES-1:0][WORD_W-1:0]    tag_q,
  output logic [ENTRIES-1:0][WORD_W-1:0]    data_q,
  output logic [ENTRIES-1:0][OWNER_W-1:0]   owner_q
);
  logic in_range;
  assign in_range = (int'(wr_idx) < ENTRIES);

  // Tag words carry the valid flag, so they are the only reset storage.
  always_ff @(posedge clk) begin
    if (rst) begin
      tag_q <= '0;
    end else if (wr_en && !wr_word && in_range) begin
      tag_q[wr_idx] <= wr_data;
    end
  end

  // Data words and owner IDs need no reset: an entry is invisible until its tag is valid.
  always_ff @(posedge clk) begin
    if (wr_en && in_range) begin
      if (wr_word) data_q[wr_idx] <= wr_data;
      else         owner_q[wr_idx] <= wr_owner;
    end
  end

  assert_reset_clears_R1: assert property (@(posedge clk) rst |=> (tag_q == '0));

  assert_owner_capture_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_word && in_range) |=> (owner_q[$past(wr_idx)] == $past(wr_owner)));
endmodule

// File: rtl/tlb_entry_match.sv
module tlb_entry_match
  import tlb_zone_pkg::*;
#(
  parameter int ENTRIES = 64
) (
  input  logic [ENTRIES-1:0][WORD_W-1:0]  tag_q,
  input  logic [ENTRIES-1:0][WORD_W-1:0]  data_q,
  input  logic [ENTRIES-1:0][OWNER_W-1:0] owner_q,
  input  logic [WORD_W-1:0]               vaddr,
  input  logic [1:0]                      acc,
  input  logic                            user,
  input  logic [OWNER_W-1:0]              pid,
  input  logic [WORD_W-1:0]               zone_reg,
  output logic [ENTRIES-1:0]              cand,
  output logic [ENTRIES-1:0]              allow,
  output logic [ENTRIES-1:0]              w_grant,
  output logic [ENTRIES-1:0]              x_grant
);
  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic [WORD_W-1:0] tw, dw, msk;
    logic [3:0] zsel;
    logic [1:0] zc;
    logic addr_ok, owner_ok, hidden;

    assign tw   = tag_q[e];
    assign dw   = data_q[e];
    assign msk  = page_mask(tw[9:7]);
    assign zsel = dw[7:4];
    // Bit index 31-2z equals {~z,1} for a 4-bit z.
    assign zc   = zone_reg[{~zsel, 1'b1} -: 2];

    assign addr_ok  = (((vaddr ^ {tw[31:OFS_MIN], {OFS_MIN{1'b0}}}) & msk) == '0);
    assign owner_ok = (owner_q[e] == '0) || (owner_q[e] == pid);
    assign hidden   = (zc == 2'd0) && user;

    assign cand[e]    = tw[6] && addr_ok && owner_ok && !hidden;
    assign w_grant[e] = dw[8] || (zc == 2'd3) || ((zc == 2'd2) && !user);
    assign x_grant[e] = dw[9] || (zc == 2'd3) || ((zc == 2'd2) && !user);
    assign allow[e]   = !((acc == ACC_WRITE) && !w_grant[e]) &&
                        !((acc == ACC_FETCH) && !x_grant[e]);

    logic unused_bits;
    assign unused_bits = ^{tw[5:0], dw[3:0]};
  end
endmodule

// File: rtl/tlb_prio_pick.sv
module tlb_prio_pick #(
  parameter int ENTRIES = 64,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] req,
  output logic               any,
  output logic [IDX_W-1:0]   idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/tlb_zone_lookup.sv
module tlb_zone_lookup
  import tlb_zone_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_word,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [31:0]       wr_data,
  input  logic [31:0]       lk_vaddr,
  input  logic [1:0]        lk_acc,
  input  logic              lk_user,
  input  logic [31:0]       cur_pid,
  input  logic [31:0]       zone_reg,
  output logic              res_hit,
  output logic              res_miss,
  output logic              res_fault,
  output logic [IDX_W-1:0]  res_idx,
  output logic [31:0]       res_paddr,
  output logic [2:0]        res_size,
  output logic              res_r,
  output logic              res_w,
  output logic              res_x
);
  logic [ENTRIES-1:0][WORD_W-1:0]  tag_q, data_q;
  logic [ENTRIES-1:0][OWNER_W-1:0] owner_q;
  logic [ENTRIES-1:0] cand, allow, w_grant, x_grant;
  logic               pick_any;
  logic [IDX_W-1:0]   pick_idx;

  logic unused_pid;
  assign unused_pid = ^cur_pid[31:OWNER_W];

  tlb_entry_store #(.ENTRIES(ENTRIES)) u_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_word(wr_word), .wr_idx(wr_idx),
    .wr_data(wr_data), .wr_owner(cur_pid[OWNER_W-1:0]),
    .tag_q(tag_q), .data_q(data_q), .owner_q(owner_q)
  );

  tlb_entry_match #(.ENTRIES(ENTRIES)) u_match (
    .tag_q(tag_q), .data_q(data_q), .owner_q(owner_q), .vaddr(lk_vaddr),
    .acc(lk_acc), .user(lk_user), .pid(cur_pid[OWNER_W-1:0]), .zone_reg(zone_reg),
    .cand(cand), .allow(allow), .w_grant(w_grant), .x_grant(x_grant)
  );

  tlb_prio_pick #(.ENTRIES(ENTRIES)) u_pick (.req(cand), .any(pick_any), .idx(pick_idx));

  logic [WORD_W-1:0] sel_tag, sel_data, sel_mask, paddr_n;
  logic              hit_n, fault_n;

  assign sel_tag  = tag_q[pick_idx];
  assign sel_data = data_q[pick_idx];
  assign sel_mask = page_mask(sel_tag[9:7]);
  assign hit_n    = pick_any && allow[pick_idx];
  assign fault_n  = pick_any && !allow[pick_idx];
  assign paddr_n  = ({sel_data[31:OFS_MIN], {OFS_MIN{1'b0}}} & sel_mask) | (lk_vaddr & ~sel_mask);

  always_ff @(posedge clk) begin
    if (rst) begin
      res_hit   <= 1'b0;
      res_miss  <= 1'b0;
      res_fault <= 1'b0;
      res_idx   <= '0;
      res_paddr <= '0;
      res_size  <= '0;
      res_r     <= 1'b0;
      res_w     <= 1'b0;
      res_x     <= 1'b0;
    end else begin
      res_hit   <= hit_n;
      res_miss  <= !pick_any;
      res_fault <= fault_n;
      res_idx   <= hit_n ? pick_idx : '0;
      res_paddr <= hit_n ? paddr_n : '0;
      res_size  <= hit_n ? sel_tag[9:7] : 3'd0;
      res_r     <= pick_any;
      res_w     <= pick_any && w_grant[pick_idx];
      res_x     <= pick_any && x_grant[pick_idx];
    end
  end

  assert_lowest_wins_R4: assert property (@(posedge clk) disable iff (rst)
    pick_any |-> (cand[pick_idx] && ((cand & ((ENTRIES'(1) << pick_idx) - ENTRIES'(1))) == '0)));

  assert_one_outcome_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({res_hit, res_miss, res_fault}));

  assert_miss_no_rights_R9: assert property (@(posedge clk) disable iff (rst)
    res_miss |-> !(res_r || res_w || res_x));

  assert_write_right_R7: assert property (@(posedge clk) disable iff (rst)
    (res_hit && ($past(lk_acc) == ACC_WRITE)) |-> res_w);

  assert_fetch_right_R7: assert property (@(posedge clk) disable iff (rst)
    (res_hit && ($past(lk_acc) == ACC_FETCH)) |-> res_x);

  assert_fault_zeroes_R7: assert property (@(posedge clk) disable iff (rst)
    res_fault |-> (res_paddr == '0 && res_idx == '0 && res_size == '0 && res_r));

  assert_read_granted_R8: assert property (@(posedge clk) disable iff (rst)
    res_hit |-> res_r);
endmodule

// File: tb/tlb_zone_lookup_bench.sv
module tlb_zone_lookup_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, wr_word = 1'b0;
  logic [5:0]  wr_idx = '0;
  logic [31:0] wr_data = '0, lk_vaddr = '0, cur_pid = '0, zone_reg = '0;
  logic [1:0]  lk_acc = '0;
  logic        lk_user = 1'b0;
  logic        res_hit, res_miss, res_fault, res_r, res_w, res_x;
  logic [5:0]  res_idx;
  logic [31:0] res_paddr;
  logic [2:0]  res_size;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  tlb_zone_lookup u_tlb_zone_lookup (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_word(wr_word), .wr_idx(wr_idx),
    .wr_data(wr_data), .lk_vaddr(lk_vaddr), .lk_acc(lk_acc), .lk_user(lk_user),
    .cur_pid(cur_pid), .zone_reg(zone_reg), .res_hit(res_hit), .res_miss(res_miss),
    .res_fault(res_fault), .res_idx(res_idx), .res_paddr(res_paddr), .res_size(res_size),
    .res_r(res_r), .res_w(res_w), .res_x(res_x)
  );

  localparam logic [2:0] HIT = 3'b100, MISS = 3'b010, FLT = 3'b001;

  function automatic logic [31:0] msk(input int code);
    return ~((32'd1024 << (2 * code)) - 32'd1);
  endfunction

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic put_tag(input int idx, input logic [31:0] va, input int code, input bit v,
                         input logic [31:0] pid);
    @(negedge clk);
    cur_pid = pid; wr_en = 1'b1; wr_word = 1'b0; wr_idx = 6'(idx);
    wr_data = (va & 32'hFFFF_FC00) | (32'(code) << 7) | (32'(v) << 6);
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic put_data(input int idx, input logic [31:0] rpn, input bit ex, input bit wr,
                          input int zone);
    @(negedge clk);
    wr_en = 1'b1; wr_word = 1'b1; wr_idx = 6'(idx);
    wr_data = (rpn & 32'hFFFF_FC00) | (32'(ex) << 9) | (32'(wr) << 8) | (32'(zone) << 4);
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic look(input logic [31:0] va, input int acc, input bit user,
                      input logic [31:0] pid, input logic [31:0] zr);
    @(negedge clk);
    lk_vaddr = va; lk_acc = 2'(acc); lk_user = user; cur_pid = pid; zone_reg = zr;
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [2:0] e_out, input int e_idx,
                       input logic [31:0] e_pa, input int e_sz, input logic [2:0] e_rwx);
    logic [46:0] got, exp;
    got = {res_hit, res_miss, res_fault, res_idx, res_paddr, res_size, res_r, res_w, res_x};
    exp = {e_out, 6'(e_idx), e_pa, 3'(e_sz), e_rwx};
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // R1: reset clears outputs and invalidates loaded entries
  task automatic t_reset();
    do_reset();
    check("R1 reset outputs", 3'b000, 0, 0, 0, 3'b000);
    put_tag(0, 32'h1000_0000, 0, 1, 0);
    put_data(0, 32'h2000_0000, 1, 1, 0);
    look(32'h1000_0004, 0, 0, 0, 32'h5555_5555);
    check("R1 loaded entry hits", HIT, 0, 32'h2000_0004, 0, 3'b111);
    do_reset();
    look(32'h1000_0004, 0, 0, 0, 32'h5555_5555);
    check("R1 R9 miss after reset", MISS, 0, 0, 0, 3'b000);
  endtask

  // R2 R8: every size code, inside and just past the page
  task automatic t_sizes();
    do_reset();
    put_data(5, 32'h2300_0000, 1, 1, 0);
    for (int c = 0; c < 8; c++) begin
      logic [31:0] sz, va;
      sz = 32'd1024 << (2 * c);
      put_tag(5, 32'h1000_0000, c, 1, 0);
      va = 32'h1000_0000 + sz - 32'd4;
      look(va, 0, 0, 0, 32'h5555_5555);
      check($sformatf("R2 R8 size code %0d inside", c), HIT, 5,
            (32'h2300_0000 & msk(c)) | (va & ~msk(c)), c, 3'b111);
      look(32'h1000_0000 + sz, 0, 0, 0, 32'h5555_5555);
      check($sformatf("R2 size code %0d beyond", c), MISS, 0, 0, 0, 3'b000);
    end
  endtask

  // R3 R10: owner ID captured at tag write, zero is a wildcard
  task automatic t_owner();
    do_reset();
    put_tag(3, 32'h3000_0000, 0, 1, 32'h2A);
    put_data(3, 32'h0050_0000, 1, 1, 0);
    look(32'h3000_03FC, 0, 0, 32'h12A, 32'h5555_5555);
    check("R3 R10 low byte of pid matches", HIT, 3, 32'h0050_03FC, 0, 3'b111);
    look(32'h3000_03FC, 0, 0, 32'h2B, 32'h5555_5555);
    check("R3 other pid misses", MISS, 0, 0, 0, 3'b000);
    put_tag(9, 32'h3000_0000, 0, 1, 32'h0);
    put_data(9, 32'h0060_0000, 1, 1, 0);
    look(32'h3000_03FC, 0, 0, 32'h2B, 32'h5555_5555);
    check("R3 zero owner is wildcard", HIT, 9, 32'h0060_03FC, 0, 3'b111);
  endtask

  // R4: lowest eligible index wins
  task automatic t_priority();
    do_reset();
    put_tag(20, 32'h0804_0000, 1, 1, 0); put_data(20, 32'h0014_0000, 1, 1, 0);
    put_tag(10, 32'h0804_0000, 1, 1, 0); put_data(10, 32'h000A_0000, 1, 1, 0);
    put_tag(4,  32'h0804_0000, 1, 1, 0); put_data(4,  32'h0004_0000, 1, 1, 0);
    look(32'h0804_0123, 0, 0, 0, 32'h5555_5555);
    check("R4 lowest of three", HIT, 4, 32'h0004_0123, 1, 3'b111);
    put_tag(4, 32'h0804_0000, 1, 0, 0);
    look(32'h0804_0123, 0, 0, 0, 32'h5555_5555);
    check("R4 next after invalidate", HIT, 10, 32'h000A_0123, 1, 3'b111);
  endtask

  // R5: zone code 0 hides an entry from user mode only
  task automatic t_zone_hide();
    logic [31:0] zr;
    do_reset();
    zr = (32'd0 << 24) | (32'd1 << 20);
    put_tag(2, 32'h4400_0000, 0, 1, 0); put_data(2, 32'h0100_0000, 1, 1, 3);
    put_tag(7, 32'h4400_0000, 0, 1, 0); put_data(7, 32'h0200_0000, 1, 1, 5);
    look(32'h4400_0010, 0, 1, 0, zr);
    check("R5 user skips hidden entry", HIT, 7, 32'h0200_0010, 0, 3'b111);
    look(32'h4400_0010, 0, 0, 0, zr);
    check("R5 supervisor sees it", HIT, 2, 32'h0100_0010, 0, 3'b111);
    look(32'h4400_0010, 0, 1, 0, 32'h0);
    check("R5 both hidden from user", MISS, 0, 0, 0, 3'b000);
  endtask

  // R6: zone codes override entry permissions
  task automatic t_zone_force();
    do_reset();
    put_tag(0, 32'h7000_0000, 0, 1, 0); put_data(0, 32'h0, 0, 0, 9);
    look(32'h7000_0010, 1, 0, 0, 32'h1 << 12);
    check("R6 code1 uses own bits", FLT, 0, 0, 0, 3'b100);
    look(32'h7000_0010, 1, 0, 0, 32'h2 << 12);
    check("R6 code2 supervisor write", HIT, 0, 32'h0000_0010, 0, 3'b111);
    look(32'h7000_0010, 1, 1, 0, 32'h2 << 12);
    check("R6 code2 user write faults", FLT, 0, 0, 0, 3'b100);
    look(32'h7000_0010, 0, 1, 0, 32'h2 << 12);
    check("R6 code2 user read", HIT, 0, 32'h0000_0010, 0, 3'b100);
    look(32'h7000_0010, 2, 1, 0, 32'h3 << 12);
    check("R6 code3 user fetch", HIT, 0, 32'h0000_0010, 0, 3'b111);
    look(32'h7000_0010, 0, 0, 0, 32'h0);
    check("R5 code0 supervisor own bits", HIT, 0, 32'h0000_0010, 0, 3'b100);
  endtask

  // R7: fault ends the search even if a later entry would allow it
  task automatic t_fault_stops();
    do_reset();
    put_tag(1, 32'h5000_0000, 2, 1, 0); put_data(1, 32'h6000_0000, 0, 0, 0);
    put_tag(8, 32'h5000_0000, 2, 1, 0); put_data(8, 32'h6100_0000, 1, 1, 0);
    look(32'h5000_1234, 1, 0, 0, 32'h4000_0000);
    check("R7 write without right", FLT, 0, 0, 0, 3'b100);
    look(32'h5000_1234, 2, 0, 0, 32'h4000_0000);
    check("R7 fetch without right", FLT, 0, 0, 0, 3'b100);
    look(32'h5000_1234, 0, 0, 0, 32'h4000_0000);
    check("R7 R8 read still hits", HIT, 1, 32'h6000_1234, 2, 3'b100);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog R9 actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_sizes();
    t_owner();
    t_priority();
    t_zone_hide();
    t_zone_force();
    t_fault_stops();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule